// File: doc/BRIEF.md
# Dual-Line Asynchronous Serial Frame Monitor

This block listens passively to two asynchronous serial lines, one for each direction of a link, and decodes every frame on each line. Both lines share one clock, one sample strobe and one set of run-time settings. Each line has its own decoder. A decoder never drives a line; it only reports what it sees. The results are the assembled data word and a set of single-cycle event pulses with their status flags.

The bit period is an integer count of sample strobes. The run-time settings are the data width (5 to 9 bits), the bit order and the parity mode. A decoder copies the settings when a frame begins, so a change made in the middle of a frame applies only from the next frame. A bad start bit, a bad parity bit or a bad stop bit raises a flag, but the frame is still decoded to the end. Every output is a two-element vector. The element index is the direction tag: 0 is the receive line and 1 is the transmit line.

Top module: `uart_dual_monitor`

## Requirements
- R1: After reset, and while both lines stay high, every event output is 0 and `dataWord` is 0.
- R2: A frame begins when a line sample is 0 and the previous sample was 1. The previous-sample register resets to 1. Take P as `bitPeriod` and N as the data width, with a strobe on every clock. Then `dataValid` is high 3 + ceil(P/2) + N·P clocks after the line is driven low: 2 synchronizer stages, 1 edge-detect sample, and the registered output.
- R3: With `msbFirst`=0, the first data bit on the line lands in word bit 0. The word is N bits wide and zero-extended to 9 bits. N is taken from `dataBits` and clamped to 5..9.
- R4: With `msbFirst`=1, the first data bit on the line lands in word bit N-1.
- R5: If the line is not 0 at the start-bit sample, `startBad` pulses with `startEvt`. The data word is still assembled.
- R6: `parityMode` 1 (odd) and 2 (even) count the ones in the data bits plus the parity bit. `parityBad` is raised when that total is not odd (mode 1) or not even (mode 2).
- R7: `parityMode` 3 requires a parity bit of 0 and mode 4 requires a parity bit of 1. Any other parity bit raises `parityBad`.
- R8: With `parityMode` 0 (or any value above 4), there is no parity slot and no `parityEvt`. The stop bit is sampled at bit index N+1 instead of N+2.
- R9: The decoder checks one stop bit. If the stop bit reads 0, `stopBad` pulses with `stopEvt`. The decoder then returns to idle, and it begins no new frame until it sees another high-to-low transition.
- R10: The two lines are decoded independently and at the same time. Each output index carries only its own line's events.
- R11: Line samples and timing advance only on clocks where `sampleEn` is high.
- R12: A change to `dataBits`, `parityMode`, `msbFirst` or `bitPeriod` during a frame does not affect that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| sampleEn | input | 1 | Sample strobe (clock enable) |
| bitPeriod | input | PERIOD_W | Bit period in sample strobes |
| dataBits | input | CNT_W | Data width, 5..9 |
| parityMode | input | 3 | 0 none, 1 odd, 2 even, 3 zero, 4 one |
| msbFirst | input | 1 | 1: first bit on the line is the word's MSB |
| rxLine | input | 1 | Receive-direction line (index 0) |
| txLine | input | 1 | Transmit-direction line (index 1) |
| dataValid | output | 2 | Pulse when the last data bit is taken |
| dataWord | output | 2*WORD_W | Assembled word; index d at [d*WORD_W +: WORD_W] |
| startEvt | output | 2 | Pulse at the start-bit sample |
| startBad | output | 2 | Start bit read 1 (with startEvt) |
| parityEvt | output | 2 | Pulse at the parity sample |
| parityBad | output | 2 | Parity check failed (with parityEvt) |
| stopEvt | output | 2 | Pulse at the stop-bit sample |
| stopBad | output | 2 | Stop bit read 0 (with stopEvt) |

## Verification
With a strobe on every clock, the start event is due 3 + ceil(P/2) clocks after the bench drives the line low. Data bit n follows n·P clocks after that, so `dataValid` arrives at 3 + ceil(P/2) + N·P. The stop event arrives at 3 + ceil(P/2) + (N+1+p)·P, where p is 1 when a parity slot exists. The bench drives the lines and samples the outputs on the falling clock edge. It stamps each drive and each event with the same cycle counter and compares the differences with these formulas. All other results are read from latched event records two bit periods after the frame ends, and by then every pulse of the frame has occurred.

// File: rtl/uartmon_pkg.sv
package uartmon_pkg;

  typedef enum logic [2:0] {
    PAR_NONE = 3'd0,
    PAR_ODD  = 3'd1,
    PAR_EVEN = 3'd2,
    PAR_ZERO = 3'd3,
    PAR_ONE  = 3'd4
  } parity_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PARITY,
    ST_STOP
  } chan_state_e;

  // strobes from control to datapath, all qualified by a sample strobe
  typedef struct packed {
    logic clear;       // falling edge seen in idle: frame begins
    logic takeStart;   // mid start bit
    logic takeData;    // mid data bit
    logic lastData;    // mid of the last data bit
    logic takeParity;  // mid parity bit
    logic takeStop;    // mid stop bit
  } strobe_t;

endpackage

// File: rtl/uartmon_ctrl.sv
module uartmon_ctrl
  import uartmon_pkg::*;
#(
  parameter int PERIOD_W = 16,
  parameter int WORD_W   = 9,
  parameter int MIN_BITS = 5,
  parameter int CNT_W    = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                sampleEn,
  input  logic                lineS,
  input  logic [PERIOD_W-1:0] bitPeriod,
  input  logic [CNT_W-1:0]    dataBits,
  input  logic [2:0]          parityMode,
  input  logic                msbFirst,
  output strobe_t             stb,
  output logic [CNT_W-1:0]    latN,
  output parity_e             latPar,
  output logic                latMsb,
  output logic                busy
);

  chan_state_e         st;
  logic [PERIOD_W-1:0] remain;
  logic [PERIOD_W-1:0] periodL;
  logic [PERIOD_W-1:0] periodSafe;
  logic [PERIOD_W:0]   halfW;
  logic [CNT_W-1:0]    bitIdx;
  logic [CNT_W-1:0]    clampN;
  parity_e             parIn;
  logic                prevS;
  logic                hit;

  always_comb begin
    periodSafe = (bitPeriod == '0) ? PERIOD_W'(1) : bitPeriod;
    halfW      = ({1'b0, periodSafe} + (PERIOD_W+1)'(1)) >> 1;
    if (dataBits < CNT_W'(MIN_BITS))     clampN = CNT_W'(MIN_BITS);
    else if (dataBits > CNT_W'(WORD_W))  clampN = CNT_W'(WORD_W);
    else                                 clampN = dataBits;
    parIn = (parityMode > 3'd4) ? PAR_NONE : parity_e'(parityMode);
  end

  always_comb begin
    hit            = sampleEn && (st != ST_IDLE) && (remain == PERIOD_W'(1));
    stb.clear      = sampleEn && (st == ST_IDLE) && prevS && !lineS;
    stb.takeStart  = hit && (st == ST_START);
    stb.takeData   = hit && (st == ST_DATA);
    stb.lastData   = stb.takeData && (bitIdx == latN - CNT_W'(1));
    stb.takeParity = hit && (st == ST_PARITY);
    stb.takeStop   = hit && (st == ST_STOP);
    busy           = (st != ST_IDLE);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      st      <= ST_IDLE;
      remain  <= '0;
      periodL <= PERIOD_W'(1);
      bitIdx  <= '0;
      latN    <= CNT_W'(MIN_BITS);
      latPar  <= PAR_NONE;
      latMsb  <= 1'b0;
      prevS   <= 1'b1;
    end else begin
      if (sampleEn) prevS <= lineS;
      if (stb.clear) begin
        st      <= ST_START;
        remain  <= halfW[PERIOD_W-1:0];
        periodL <= periodSafe;
        latN    <= clampN;
        latPar  <= parIn;
        latMsb  <= msbFirst;
        bitIdx  <= '0;
      end else if (hit) begin
        remain <= periodL;
        unique case (st)
          ST_START:  st <= ST_DATA;
          ST_DATA: begin
            if (stb.lastData) st <= (latPar == PAR_NONE) ? ST_STOP : ST_PARITY;
            else              bitIdx <= bitIdx + CNT_W'(1);
          end
          ST_PARITY: st <= ST_STOP;
          ST_STOP:   st <= ST_IDLE;
          default:   st <= ST_IDLE;
        endcase
      end else if (sampleEn && (st != ST_IDLE)) begin
        remain <= remain - PERIOD_W'(1);
      end
    end
  end

  // R12: latched settings hold for the whole frame
  p_cfg_hold_r12: assert property (@(posedge clk) disable iff (!rstN)
    (st != ST_IDLE && $past(st) != ST_IDLE) |->
      ($stable(latN) && $stable(latPar) && $stable(latMsb) && $stable(periodL)));

  // R2: the bit-timing counter never stalls at zero inside a frame
  p_remain_live_r2: assert property (@(posedge clk) disable iff (!rstN)
    (st != ST_IDLE) |-> (remain != '0));

endmodule

// File: rtl/uartmon_dp.sv
module uartmon_dp
  import uartmon_pkg::*;
#(
  parameter int WORD_W = 9,
  parameter int CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              lineRaw,
  input  strobe_t           stb,
  input  logic [CNT_W-1:0]  latN,
  input  parity_e           latPar,
  input  logic              latMsb,
  output logic              lineS,
  output logic [WORD_W-1:0] dataWord,
  output logic              dataValid,
  output logic              startEvt,
  output logic              startBad,
  output logic              parityEvt,
  output logic              parityBad,
  output logic              stopEvt,
  output logic              stopBad
);

  logic              syncA;
  logic              syncB;
  logic [WORD_W-1:0] insertLsb;
  logic              onesOdd;
  logic              parOk;

  assign lineS = syncB;

  always_comb begin
    insertLsb = {{(WORD_W-1){1'b0}}, lineS} << (latN - CNT_W'(1));
    onesOdd   = (^dataWord) ^ lineS;
    unique case (latPar)
      PAR_ODD:  parOk = onesOdd;
      PAR_EVEN: parOk = !onesOdd;
      PAR_ZERO: parOk = !lineS;
      PAR_ONE:  parOk = lineS;
      default:  parOk = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncA     <= 1'b1;
      syncB     <= 1'b1;
      dataWord  <= '0;
      dataValid <= 1'b0;
      startEvt  <= 1'b0;
      startBad  <= 1'b0;
      parityEvt <= 1'b0;
      parityBad <= 1'b0;
      stopEvt   <= 1'b0;
      stopBad   <= 1'b0;
    end else begin
      syncA     <= lineRaw;
      syncB     <= syncA;
      dataValid <= stb.lastData;
      startEvt  <= stb.takeStart;
      startBad  <= stb.takeStart && lineS;
      parityEvt <= stb.takeParity;
      parityBad <= stb.takeParity && !parOk;
      stopEvt   <= stb.takeStop;
      stopBad   <= stb.takeStop && !lineS;
      if (stb.clear)
        dataWord <= '0;
      else if (stb.takeData)
        dataWord <= latMsb ? {dataWord[WORD_W-2:0], lineS} : ((dataWord >> 1) | insertLsb);
    end
  end

  // R3: a finished word has nothing above its configured width
  p_word_fits_r3: assert property (@(posedge clk) disable iff (!rstN)
    dataValid |-> ((dataWord >> latN) == '0));

  // R5: the start flag only comes with its event
  p_start_flag_r5: assert property (@(posedge clk) disable iff (!rstN)
    startBad |-> startEvt);

endmodule

// File: rtl/uart_dual_monitor.sv
module uart_dual_monitor
  import uartmon_pkg::*;
#(
  parameter int PERIOD_W = 16,
  parameter int WORD_W   = 9,
  parameter int MIN_BITS = 5,
  localparam int CNT_W   = $clog2(WORD_W + 1),
  localparam int NUM_DIR = 2
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      sampleEn,
  input  logic [PERIOD_W-1:0]       bitPeriod,
  input  logic [CNT_W-1:0]          dataBits,
  input  logic [2:0]                parityMode,
  input  logic                      msbFirst,
  input  logic                      rxLine,
  input  logic                      txLine,
  output logic [NUM_DIR-1:0]        dataValid,
  output logic [NUM_DIR*WORD_W-1:0] dataWord,
  output logic [NUM_DIR-1:0]        startEvt,
  output logic [NUM_DIR-1:0]        startBad,
  output logic [NUM_DIR-1:0]        parityEvt,
  output logic [NUM_DIR-1:0]        parityBad,
  output logic [NUM_DIR-1:0]        stopEvt,
  output logic [NUM_DIR-1:0]        stopBad
);

  logic [NUM_DIR-1:0] lines;
  assign lines = {txLine, rxLine};

  for (genvar d = 0; d < NUM_DIR; d++) begin : g_dir
    strobe_t          stb;
    logic [CNT_W-1:0] latN;
    parity_e          latPar;
    logic             latMsb;
    logic             busy;
    logic             lineS;

    uartmon_ctrl #(
      .PERIOD_W(PERIOD_W), .WORD_W(WORD_W), .MIN_BITS(MIN_BITS), .CNT_W(CNT_W)
    ) i_ctrl (
      .clk(clk), .rstN(rstN), .sampleEn(sampleEn), .lineS(lineS),
      .bitPeriod(bitPeriod), .dataBits(dataBits), .parityMode(parityMode),
      .msbFirst(msbFirst), .stb(stb), .latN(latN), .latPar(latPar),
      .latMsb(latMsb), .busy(busy)
    );

    uartmon_dp #(.WORD_W(WORD_W), .CNT_W(CNT_W)) i_dp (
      .clk(clk), .rstN(rstN), .lineRaw(lines[d]), .stb(stb), .latN(latN),
      .latPar(latPar), .latMsb(latMsb), .lineS(lineS),
      .dataWord(dataWord[d*WORD_W +: WORD_W]), .dataValid(dataValid[d]),
      .startEvt(startEvt[d]), .startBad(startBad[d]),
      .parityEvt(parityEvt[d]), .parityBad(parityBad[d]),
      .stopEvt(stopEvt[d]), .stopBad(stopBad[d])
    );

    // R9: the stop sample always hands the channel back to idle
    p_stop_ends_frame_r9: assert property (@(posedge clk) disable iff (!rstN)
      stopEvt[d] |-> !busy);

    // R2: events of one frame never overlap in a cycle
    p_one_event_r2: assert property (@(posedge clk) disable iff (!rstN)
      $onehot0({startEvt[d], dataValid[d], parityEvt[d], stopEvt[d]}));

    // R11: a data word completes only on a strobed sample
    p_valid_on_strobe_r11: assert property (@(posedge clk) disable iff (!rstN)
      dataValid[d] |-> $past(sampleEn));

    // R8: no parity event when the frame has no parity slot
    p_no_parity_slot_r8: assert property (@(posedge clk) disable iff (!rstN)
      parityEvt[d] |-> (latPar != PAR_NONE));
  end

endmodule

// File: tb/test_uart_dual_monitor.sv
module test_uart_dual_monitor;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        sampleEn = 1'b1;
  logic        gate = 1'b0;
  logic [15:0] period = 16'd8;
  logic [3:0]  dataBits = 4'd8;
  logic [2:0]  parityMode = 3'd0;
  logic        msbFirst = 1'b0;
  logic [1:0]  lineReg = 2'b11;

  logic [1:0]  dataValid, startEvt, startBad, parityEvt, parityBad, stopEvt, stopBad;
  logic [17:0] dataWord;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  bit done = 0;

  int nValid[2], nStart[2], nPar[2], nStop[2];
  int validCyc[2], stopCyc[2], driveCyc[2];
  int lastWord[2];
  int sBad[2], pBad[2], tBad[2];

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) sampleEn <= gate ? ~sampleEn : 1'b1;

  uart_dual_monitor i_uart_dual_monitor (
    .clk(clk), .rstN(rstN), .sampleEn(sampleEn), .bitPeriod(period),
    .dataBits(dataBits), .parityMode(parityMode), .msbFirst(msbFirst),
    .rxLine(lineReg[0]), .txLine(lineReg[1]),
    .dataValid(dataValid), .dataWord(dataWord), .startEvt(startEvt),
    .startBad(startBad), .parityEvt(parityEvt), .parityBad(parityBad),
    .stopEvt(stopEvt), .stopBad(stopBad)
  );

  always @(negedge clk) begin
    for (int d = 0; d < 2; d++) begin
      if (dataValid[d]) begin
        nValid[d]++; validCyc[d] = cyc; lastWord[d] = int'(dataWord[d*9 +: 9]);
      end
      if (startEvt[d]) begin nStart[d]++; sBad[d] = int'(startBad[d]); end
      if (parityEvt[d]) begin nPar[d]++; pBad[d] = int'(parityBad[d]); end
      if (stopEvt[d]) begin nStop[d]++; tBad[d] = int'(stopBad[d]); stopCyc[d] = cyc; end
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // drive one frame; mult = clocks per sample strobe
  task automatic sendFrame(input int d, input int val, input int n, input bit msb,
                           input int pm, input bit flip, input bit stopVal,
                           input bit glitch, input bit tailHigh, input int mult);
    int per;
    int ones;
    bit p;
    per = int'(period) * mult;
    @(negedge clk);
    lineReg[d] = 1'b0;
    driveCyc[d] = cyc;
    if (glitch) begin
      @(negedge clk);
      lineReg[d] = 1'b1;
      repeat (per - 1) @(negedge clk);
    end else begin
      repeat (per) @(negedge clk);
    end
    for (int i = 0; i < n; i++) begin
      lineReg[d] = msb ? val[n-1-i] : val[i];
      repeat (per) @(negedge clk);
    end
    if (pm != 0) begin
      ones = $countones(val & ((1 << n) - 1));
      case (pm)
        1: p = (ones % 2 == 0);
        2: p = (ones % 2 == 1);
        3: p = 1'b0;
        default: p = 1'b1;
      endcase
      lineReg[d] = p ^ flip;
      repeat (per) @(negedge clk);
    end
    lineReg[d] = stopVal;
    repeat (per) @(negedge clk);
    if (tailHigh) begin
      lineReg[d] = 1'b1;
      repeat (2 * per) @(negedge clk);
    end
  endtask

  task automatic setCfg(input int p, input int n, input int pm, input bit msb);
    @(negedge clk);
    period = 16'(p); dataBits = 4'(n); parityMode = 3'(pm); msbFirst = msb;
  endtask

  task automatic tReset;
    repeat (20) @(negedge clk);
    chk("R1", "event outputs after reset",
        int'({dataValid, startEvt, startBad, parityEvt, parityBad, stopEvt, stopBad}), 0);
    chk("R1", "dataWord after reset", int'(dataWord), 0);
    chk("R1", "no starts on idle lines", nStart[0] + nStart[1], 0);
  endtask

  task automatic tLsb;
    int v0, t0;
    setCfg(8, 8, 0, 0);
    v0 = nValid[0]; t0 = nStart[1];
    sendFrame(0, 'hA5, 8, 0, 0, 0, 1, 0, 1, 1);
    chk("R3", "lsb-first word", lastWord[0], 'hA5);
    chk("R2", "one data word", nValid[0] - v0, 1);
    chk("R2", "valid latency", validCyc[0] - driveCyc[0], 3 + 4 + 8 * 8);
    chk("R10", "other line silent", nStart[1] - t0, 0);
  endtask

  task automatic tWidths;
    setCfg(5, 5, 0, 0);
    sendFrame(0, 'h13, 5, 0, 0, 0, 1, 0, 1, 1);
    chk("R3", "5-bit word", lastWord[0], 'h13);
    chk("R2", "5-bit latency odd period", validCyc[0] - driveCyc[0], 3 + 3 + 5 * 5);
    setCfg(8, 9, 0, 0);
    sendFrame(1, 'h1A6, 9, 0, 0, 0, 1, 0, 1, 1);
    chk("R3", "9-bit word", lastWord[1], 'h1A6);
  endtask

  task automatic tMsb;
    setCfg(8, 8, 0, 1);
    sendFrame(0, 'hC1, 8, 1, 0, 0, 1, 0, 1, 1);
    chk("R4", "msb-first 8-bit", lastWord[0], 'hC1);
    setCfg(8, 6, 0, 1);
    sendFrame(1, 'h2D, 6, 1, 0, 0, 1, 0, 1, 1);
    chk("R4", "msb-first 6-bit", lastWord[1], 'h2D);
  endtask

  task automatic tParity;
    int p0;
    for (int pm = 1; pm <= 4; pm++) begin
      for (int f = 0; f < 2; f++) begin
        setCfg(8, 8, pm, 0);
        p0 = nPar[0];
        sendFrame(0, 'h5B, 8, 0, pm, f[0], 1, 0, 1, 1);
        chk(pm <= 2 ? "R6" : "R7", $sformatf("parity flag mode %0d flip %0d", pm, f), pBad[0], f);
        chk(pm <= 2 ? "R6" : "R7", "one parity event", nPar[0] - p0, 1);
      end
    end
    chk("R6", "word intact after parity error", lastWord[0], 'h5B);
    setCfg(6, 7, 1, 0);
    sendFrame(0, 'h3A, 7, 0, 1, 0, 1, 0, 1, 1);
    chk("R8", "stop at N+2 with parity", stopCyc[0] - driveCyc[0], 3 + 3 + 9 * 6);
  endtask

  task automatic tNone;
    int p0;
    setCfg(6, 7, 0, 0);
    p0 = nPar[0];
    sendFrame(0, 'h3A, 7, 0, 0, 0, 1, 0, 1, 1);
    chk("R8", "no parity event", nPar[0] - p0, 0);
    chk("R8", "stop at N+1 without parity", stopCyc[0] - driveCyc[0], 3 + 3 + 8 * 6);
    chk("R8", "stop good", tBad[0], 0);
  endtask

  task automatic tStartGlitch;
    int s0;
    setCfg(8, 8, 0, 0);
    s0 = nStart[0];
    sendFrame(0, 'h3C, 8, 0, 0, 0, 1, 1, 1, 1);
    chk("R5", "bad start flagged", sBad[0], 1);
    chk("R5", "frame continued", lastWord[0], 'h3C);
    chk("R5", "one start event", nStart[0] - s0, 1);
  endtask

  task automatic tStopBad;
    int s0;
    setCfg(8, 8, 0, 0);
    s0 = nStart[0];
    sendFrame(0, 'h81, 8, 0, 0, 0, 0, 0, 0, 1);
    repeat (30 * 8) @(negedge clk);
    chk("R9", "framing error flagged", tBad[0], 1);
    chk("R9", "no frame while line stays low", nStart[0] - s0, 1);
    lineReg[0] = 1'b1;
    repeat (16) @(negedge clk);
    sendFrame(0, 'h42, 8, 0, 0, 0, 1, 0, 1, 1);
    chk("R9", "next frame after recovery", lastWord[0], 'h42);
    chk("R9", "next stop good", tBad[0], 0);
  endtask

  task automatic tDual;
    int v0, v1;
    setCfg(8, 8, 2, 0);
    v0 = nValid[0]; v1 = nValid[1];
    fork
      sendFrame(0, 'h96, 8, 0, 2, 0, 1, 0, 1, 1);
      begin repeat (13) @(negedge clk); sendFrame(1, 'h4B, 8, 0, 2, 1, 1, 0, 1, 1); end
    join
    chk("R10", "rx word", lastWord[0], 'h96);
    chk("R10", "tx word", lastWord[1], 'h4B);
    chk("R10", "rx parity ok", pBad[0], 0);
    chk("R10", "tx parity error on its own index", pBad[1], 1);
    chk("R10", "one word each", (nValid[0] - v0) * 10 + (nValid[1] - v1), 11);
  endtask

  task automatic tGate;
    setCfg(8, 8, 0, 0);
    gate = 1'b1;
    sendFrame(1, 'h71, 8, 0, 0, 0, 1, 0, 1, 2);
    chk("R11", "word with half-rate strobe", lastWord[1], 'h71);
    chk("R11", "stop good with half-rate strobe", tBad[1], 0);
    gate = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic tCfg;
    int p0;
    setCfg(8, 8, 0, 0);
    p0 = nPar[0];
    fork
      sendFrame(0, 'hE4, 8, 0, 0, 0, 1, 0, 1, 1);
      begin
        repeat (30) @(negedge clk);
        dataBits = 4'd5; msbFirst = 1'b1; parityMode = 3'd4; period = 16'd3;
      end
    join
    chk("R12", "word unaffected by mid-frame change", lastWord[0], 'hE4);
    chk("R12", "timing unaffected", validCyc[0] - driveCyc[0], 3 + 4 + 8 * 8);
    chk("R12", "no parity slot added", nPar[0] - p0, 0);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    tReset();
    tLsb();
    tWidths();
    tMsb();
    tParity();
    tNone();
    tStartGlitch();
    tStopBad();
    tDual();
    tGate();
    tCfg();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog (all requirements): actual=still running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule